// File: doc/BRIEF.md
# Dual Converging Stack Controller

This block manages the two stacks of a stack-oriented processor inside one 256-byte window of byte memory. The window starts at a base address that is aligned to 16 bytes. The data stack starts at window offset 24, just above the register area, and grows toward higher offsets. The return stack starts at the top of the window and grows toward lower offsets. Both stack pointers are 8-bit offsets into the same window, so the two stacks grow toward each other.

The top data element lives in a dedicated register and is never fetched from memory while it is on top. A separate operation reads the element just below it without removing it. The return stack holds return addresses, temporary local bytes, and any extra state bytes pushed on interrupt entry. The block also gives direct byte read and write access to any offset in the window. In hardware it catches a push that would make the stacks meet and a pop from an empty stack. In both cases it suppresses the operation and raises a sticky flag.

The block accepts one operation per clock on a 4-bit code. Memory reads have a one-cycle latency. A popped data byte appears on the top-of-stack output in the cycle after the pop. Bytes returned by the other read operations appear on the read-data output in the cycle after the operation, with the read-valid strobe high.

Top module: `stack_pair_ctrl`

## Requirements
- R1: After reset the data pointer is 24, the return pointer is 0 (the top of the window, 256 wrapped to 8 bits), the top-of-stack output is 0, both error flags are low and read-valid is low.
- R2: Code 1 (data push) stores the current top byte at window offset equal to the data pointer, increments the data pointer, and loads the write-data byte as the new top. All of this is visible in the next cycle.
- R3: Code 2 (data pop) decrements the data pointer and loads the byte at the new data pointer into the top register, and the byte is visible on the top output in the next cycle. The result is correct when pops come back to back and when a push directly follows a pop.
- R4: Code 3 (next peek) returns the byte just below the top (offset data pointer minus 1) on read-data with read-valid high in the next cycle. The pointers and the top byte stay unchanged.
- R5: Code 4 (return push) decrements the return pointer and then stores the write-data byte at the new offset. Code 5 (return pop) reads the byte at the return pointer, returns it on read-data with read-valid in the next cycle, and then increments the pointer. Together the two behave last-in first-out.
- R6: Code 6 (return peek) returns the byte at the return pointer on read-data with read-valid in the next cycle and leaves the return pointer unchanged.
- R7: A data or return push is refused when the return pointer (with 0 read as 256) minus the data pointer is 1 or less. A refused push changes no pointer, no top byte and no memory, and it sets the collision flag. The flag stays set until it is cleared.
- R8: A data pop or next peek while the data pointer is 24, and a return pop or return peek while the return pointer is 0, is refused. A refused pop or peek changes nothing, does not raise read-valid, and sets the sticky underflow flag.
- R9: Code 7 reads and code 8 writes the window byte at offset `off_i`. The memory address is `bp_i` with its low 4 bits forced to zero, plus the offset, wrapping modulo the memory size. A read returns its byte on read-data with read-valid in the next cycle.
- R10: Code 9 clears both error flags in the next cycle.
- R11: Code 0 and codes 10 to 15 change no pointer, no top byte, no flag and no memory, and do not raise read-valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bp_i | input | ADDR_W | Window base address (low 4 bits ignored) |
| op_i | input | 4 | Operation code for this cycle |
| wdata_i | input | DATA_W | Byte for pushes and window writes |
| off_i | input | OFF_W | Window offset for direct access |
| tos_o | output | DATA_W | Top data-stack byte |
| rd_data_o | output | DATA_W | Byte returned by peeks, return pops and window reads |
| rd_valid_o | output | 1 | rd_data_o carries a result this cycle |
| dsp_o | output | OFF_W | Data stack pointer (offset of next free data slot) |
| rsp_o | output | OFF_W | Return stack pointer (offset of top return byte) |
| coll_err_o | output | 1 | Sticky collision flag |
| udf_err_o | output | 1 | Sticky underflow flag |

## Verification
The bound checker watches every cycle for the following: the data pointer must stay strictly below the return pointer, and it must never drop under 24. A permitted push must move the data pointer up by one and load the top byte. A refused push must freeze both pointers and raise the collision flag, and the flag must stay set until a clear. Permitted return pops and next peeks must strobe read-valid. Only the bench's scenarios can show that the stored bytes are the right ones. That covers last-in first-out order through memory, the top-byte bypass when a pop is directly followed by another pop or a push, the alignment and wrap of direct window accesses, and the exact depth at which the two stacks meet.

// File: rtl/stack_pair_pkg.sv
package stack_pair_pkg;

  typedef enum logic [3:0] {
    OP_NOP   = 4'd0,
    OP_DPUSH = 4'd1,
    OP_DPOP  = 4'd2,
    OP_DPEEK = 4'd3,
    OP_RPUSH = 4'd4,
    OP_RPOP  = 4'd5,
    OP_RPEEK = 4'd6,
    OP_WRD   = 4'd7,
    OP_WWR   = 4'd8,
    OP_CLR   = 4'd9
  } op_e;

endpackage

// File: rtl/stack_pair_ram.sv
module stack_pair_ram #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // single port, registered read, no reset: maps onto block RAM
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    rdata     <= mem[addr];
    end
  end
endmodule

// File: rtl/stack_pair_tos.sv
module stack_pair_tos #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,     // push: take new byte
  input  logic [DATA_W-1:0] load_val,
  input  logic              fetch,    // pop: byte arrives from RAM next cycle
  input  logic [DATA_W-1:0] ram_q,
  output logic [DATA_W-1:0] tos
);
  logic [DATA_W-1:0] tos_q;
  logic              pend_q;

  // while a fetched byte is pending, the RAM output register is the top
  assign tos = pend_q ? ram_q : tos_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tos_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (pend_q) tos_q <= ram_q;
      if (load)   tos_q <= load_val;
      pend_q <= fetch;
    end
  end
endmodule

// File: rtl/stack_pair_ptrs.sv
module stack_pair_ptrs
  import stack_pair_pkg::*;
#(
  parameter int OFF_W       = 8,
  parameter int DSTACK_BASE = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  op_e              op,
  input  logic [OFF_W-1:0] off,
  output logic [OFF_W-1:0] dsp_q,
  output logic [OFF_W-1:0] rsp_q,
  output logic             mem_en,
  output logic             mem_we,
  output logic [OFF_W-1:0] mem_off,
  output logic             wr_tos,    // write source is the top byte
  output logic             tos_load,
  output logic             tos_fetch,
  output logic             rd_req,
  output logic             coll_q,
  output logic             udf_q
);
  localparam logic [OFF_W-1:0] DBASE = OFF_W'(DSTACK_BASE);
  localparam logic [OFF_W-1:0] STEP  = OFF_W'(1);
  localparam logic [OFF_W:0]   ONE_X = (OFF_W+1)'(1);

  logic [OFF_W:0]   rsp_ext, room;
  logic             full, d_empty, r_empty;
  logic [OFF_W-1:0] dsp_n, rsp_n;
  logic             coll_set, udf_set, clr;

  // return pointer 0 stands for the (unreachable in 8 bits) offset 256
  assign rsp_ext = {(rsp_q == '0), rsp_q};
  assign room    = rsp_ext - {1'b0, dsp_q};
  assign full    = (room <= ONE_X);
  assign d_empty = (dsp_q == DBASE);
  assign r_empty = (rsp_q == '0);

  always_comb begin
    dsp_n     = dsp_q;
    rsp_n     = rsp_q;
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_off   = off;
    wr_tos    = 1'b0;
    tos_load  = 1'b0;
    tos_fetch = 1'b0;
    rd_req    = 1'b0;
    coll_set  = 1'b0;
    udf_set   = 1'b0;
    clr       = 1'b0;
    unique case (op)
      OP_DPUSH: begin
        if (full) coll_set = 1'b1;
        else begin
          mem_en   = 1'b1;
          mem_we   = 1'b1;
          mem_off  = dsp_q;
          wr_tos   = 1'b1;
          tos_load = 1'b1;
          dsp_n    = dsp_q + STEP;
        end
      end
      OP_DPOP: begin
        if (d_empty) udf_set = 1'b1;
        else begin
          mem_en    = 1'b1;
          mem_off   = dsp_q - STEP;
          tos_fetch = 1'b1;
          dsp_n     = dsp_q - STEP;
        end
      end
      OP_DPEEK: begin
        if (d_empty) udf_set = 1'b1;
        else begin
          mem_en  = 1'b1;
          mem_off = dsp_q - STEP;
          rd_req  = 1'b1;
        end
      end
      OP_RPUSH: begin
        if (full) coll_set = 1'b1;
        else begin
          mem_en  = 1'b1;
          mem_we  = 1'b1;
          mem_off = rsp_q - STEP;
          rsp_n   = rsp_q - STEP;
        end
      end
      OP_RPOP: begin
        if (r_empty) udf_set = 1'b1;
        else begin
          mem_en  = 1'b1;
          mem_off = rsp_q;
          rd_req  = 1'b1;
          rsp_n   = rsp_q + STEP;
        end
      end
      OP_RPEEK: begin
        if (r_empty) udf_set = 1'b1;
        else begin
          mem_en  = 1'b1;
          mem_off = rsp_q;
          rd_req  = 1'b1;
        end
      end
      OP_WRD: begin
        mem_en = 1'b1;
        rd_req = 1'b1;
      end
      OP_WWR: begin
        mem_en = 1'b1;
        mem_we = 1'b1;
      end
      OP_CLR:  clr = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dsp_q  <= DBASE;
      rsp_q  <= '0;
      coll_q <= 1'b0;
      udf_q  <= 1'b0;
    end else begin
      dsp_q  <= dsp_n;
      rsp_q  <= rsp_n;
      coll_q <= clr ? 1'b0 : (coll_q | coll_set);
      udf_q  <= clr ? 1'b0 : (udf_q | udf_set);
    end
  end
endmodule

// File: rtl/stack_pair_ctrl.sv
module stack_pair_ctrl
  import stack_pair_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 8,
  parameter int OFF_W       = 8,
  parameter int DSTACK_BASE = 24,
  parameter int ALIGN_W     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bp_i,
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [DATA_W-1:0] tos_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic [OFF_W-1:0]  dsp_o,
  output logic [OFF_W-1:0]  rsp_o,
  output logic              coll_err_o,
  output logic              udf_err_o
);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'((1 << ALIGN_W) - 1);
  localparam int                PAD_W      = ADDR_W - OFF_W;

  op_e               op;
  logic              mem_en, mem_we, wr_tos, tos_load, tos_fetch, rd_req;
  logic [OFF_W-1:0]  mem_off;
  logic [ADDR_W-1:0] base, addr;
  logic [DATA_W-1:0] ram_q, ram_wd, tos;

  assign op   = op_e'(op_i);
  assign base = bp_i & ALIGN_MASK;
  assign addr = base + {{PAD_W{1'b0}}, mem_off};

  stack_pair_ptrs #(.OFF_W(OFF_W), .DSTACK_BASE(DSTACK_BASE)) u_ptrs (
    .clk(clk), .rst(rst), .op(op), .off(off_i),
    .dsp_q(dsp_o), .rsp_q(rsp_o),
    .mem_en(mem_en), .mem_we(mem_we), .mem_off(mem_off),
    .wr_tos(wr_tos), .tos_load(tos_load), .tos_fetch(tos_fetch),
    .rd_req(rd_req), .coll_q(coll_err_o), .udf_q(udf_err_o)
  );

  assign ram_wd = wr_tos ? tos : wdata_i;

  stack_pair_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk(clk), .en(mem_en), .we(mem_we), .addr(addr),
    .wdata(ram_wd), .rdata(ram_q)
  );

  stack_pair_tos #(.DATA_W(DATA_W)) u_tos (
    .clk(clk), .rst(rst), .load(tos_load), .load_val(wdata_i),
    .fetch(tos_fetch), .ram_q(ram_q), .tos(tos)
  );

  assign tos_o     = tos;
  assign rd_data_o = ram_q;

  always_ff @(posedge clk) begin
    if (rst) rd_valid_o <= 1'b0;
    else     rd_valid_o <= rd_req;
  end
endmodule

// File: rtl/stack_pair_ctrl_chk.sv
module stack_pair_ctrl_chk
  import stack_pair_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OFF_W       = 8,
  parameter int DSTACK_BASE = 24
) (
  input logic              clk,
  input logic              rst,
  input logic [3:0]        op_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] tos_o,
  input logic              rd_valid_o,
  input logic [OFF_W-1:0]  dsp_o,
  input logic [OFF_W-1:0]  rsp_o,
  input logic              coll_err_o,
  input logic              udf_err_o
);
  localparam logic [OFF_W-1:0] DBASE = OFF_W'(DSTACK_BASE);

  logic [OFF_W:0] top_ext;
  logic           no_room, is_push;
  assign top_ext = {(rsp_o == '0), rsp_o};
  assign no_room = ({1'b0, dsp_o} + (OFF_W+1)'(1)) >= top_ext;
  assign is_push = (op_i == OP_DPUSH) || (op_i == OP_RPUSH);

  p_no_overlap_r7: assert property (@(posedge clk) disable iff (rst)
    {1'b0, dsp_o} < top_ext);

  p_dsp_floor_r8: assert property (@(posedge clk) disable iff (rst)
    dsp_o >= DBASE);

  p_push_ok_r2: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_DPUSH && !no_room) |=>
      (dsp_o == OFF_W'($past(dsp_o) + 1'b1)) && (tos_o == $past(wdata_i)));

  p_collide_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (is_push && no_room) |=> coll_err_o && $stable(dsp_o) && $stable(rsp_o));

  p_coll_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (coll_err_o && op_i != OP_CLR) |=> coll_err_o);

  p_underflow_r8: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_DPOP && dsp_o == DBASE) |=>
      udf_err_o && $stable(dsp_o) && $stable(tos_o));

  p_clear_r10: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_CLR) |=> !coll_err_o && !udf_err_o);

  p_rpop_r5: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_RPOP && rsp_o != '0) |=>
      rd_valid_o && (rsp_o == OFF_W'($past(rsp_o) + 1'b1)));

  p_peek_r4: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_DPEEK && dsp_o != DBASE) |=>
      rd_valid_o && $stable(dsp_o) && $stable(tos_o));
endmodule

bind stack_pair_ctrl stack_pair_ctrl_chk #(
  .DATA_W(DATA_W), .OFF_W(OFF_W), .DSTACK_BASE(DSTACK_BASE)
) u_chk (
  .clk(clk), .rst(rst), .op_i(op_i), .wdata_i(wdata_i), .tos_o(tos_o),
  .rd_valid_o(rd_valid_o), .dsp_o(dsp_o), .rsp_o(rsp_o),
  .coll_err_o(coll_err_o), .udf_err_o(udf_err_o)
);

// File: tb/stack_pair_ctrl_tb.sv
module stack_pair_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] bp_i = 10'h120;
  logic [3:0] op_i = 4'd0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] off_i = 8'h00;
  logic [7:0] tos_o, rd_data_o, dsp_o, rsp_o;
  logic       rd_valid_o, coll_err_o, udf_err_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  stack_pair_ctrl u_dut (
    .clk(clk), .rst(rst), .bp_i(bp_i), .op_i(op_i), .wdata_i(wdata_i),
    .off_i(off_i), .tos_o(tos_o), .rd_data_o(rd_data_o),
    .rd_valid_o(rd_valid_o), .dsp_o(dsp_o), .rsp_o(rsp_o),
    .coll_err_o(coll_err_o), .udf_err_o(udf_err_o)
  );

  // {op, wdata, off, exp_tos, exp_dsp, exp_rsp, exp_rdv, exp_rd, exp_coll, exp_udf}
  localparam int NV = 24;
  localparam logic [54:0] VEC [NV] = '{
    {4'h1, 8'hA1, 8'h00, 8'hA1, 8'd25, 8'd0,   1'b0, 8'h00, 1'b0, 1'b0},
    {4'h1, 8'hB2, 8'h00, 8'hB2, 8'd26, 8'd0,   1'b0, 8'h00, 1'b0, 1'b0},
    {4'h1, 8'hC3, 8'h00, 8'hC3, 8'd27, 8'd0,   1'b0, 8'h00, 1'b0, 1'b0},
    {4'h3, 8'h00, 8'h00, 8'hC3, 8'd27, 8'd0,   1'b1, 8'hB2, 1'b0, 1'b0},
    {4'h2, 8'h00, 8'h00, 8'hB2, 8'd26, 8'd0,   1'b0, 8'h00, 1'b0, 1'b0},
    {4'h2, 8'h00, 8'h00, 8'hA1, 8'd25, 8'd0,   1'b0, 8'h00, 1'b0, 1'b0},
    {4'h1, 8'hD4, 8'h00, 8'hD4, 8'd26, 8'd0,   1'b0, 8'h00, 1'b0, 1'b0},
    {4'h2, 8'h00, 8'h00, 8'hA1, 8'd25, 8'd0,   1'b0, 8'h00, 1'b0, 1'b0},
    {4'h4, 8'h55, 8'h00, 8'hA1, 8'd25, 8'd255, 1'b0, 8'h00, 1'b0, 1'b0},
    {4'h4, 8'h66, 8'h00, 8'hA1, 8'd25, 8'd254, 1'b0, 8'h00, 1'b0, 1'b0},
    {4'h6, 8'h00, 8'h00, 8'hA1, 8'd25, 8'd254, 1'b1, 8'h66, 1'b0, 1'b0},
    {4'h5, 8'h00, 8'h00, 8'hA1, 8'd25, 8'd255, 1'b1, 8'h66, 1'b0, 1'b0},
    {4'h7, 8'h00, 8'hFF, 8'hA1, 8'd25, 8'd255, 1'b1, 8'h55, 1'b0, 1'b0},
    {4'h7, 8'h00, 8'd24, 8'hA1, 8'd25, 8'd255, 1'b1, 8'h00, 1'b0, 1'b0},
    {4'h8, 8'h77, 8'd40, 8'hA1, 8'd25, 8'd255, 1'b0, 8'h00, 1'b0, 1'b0},
    {4'h7, 8'h00, 8'd40, 8'hA1, 8'd25, 8'd255, 1'b1, 8'h77, 1'b0, 1'b0},
    {4'h5, 8'h00, 8'h00, 8'hA1, 8'd25, 8'd0,   1'b1, 8'h55, 1'b0, 1'b0},
    {4'h5, 8'h00, 8'h00, 8'hA1, 8'd25, 8'd0,   1'b0, 8'h00, 1'b0, 1'b1},
    {4'h2, 8'h00, 8'h00, 8'h00, 8'd24, 8'd0,   1'b0, 8'h00, 1'b0, 1'b1},
    {4'h2, 8'h00, 8'h00, 8'h00, 8'd24, 8'd0,   1'b0, 8'h00, 1'b0, 1'b1},
    {4'h3, 8'h00, 8'h00, 8'h00, 8'd24, 8'd0,   1'b0, 8'h00, 1'b0, 1'b1},
    {4'hF, 8'h99, 8'h10, 8'h00, 8'd24, 8'd0,   1'b0, 8'h00, 1'b0, 1'b1},
    {4'h9, 8'h00, 8'h00, 8'h00, 8'd24, 8'd0,   1'b0, 8'h00, 1'b0, 1'b0},
    {4'h1, 8'hEE, 8'h00, 8'hEE, 8'd25, 8'd0,   1'b0, 8'h00, 1'b0, 1'b0}
  };

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'h1: return "R2";
      4'h2: return "R3";
      4'h3: return "R4";
      4'h4, 4'h5: return "R5";
      4'h6: return "R6";
      4'h7, 4'h8: return "R9";
      4'h9: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // drive one operation at a falling edge; return at the next falling edge
  task automatic step(input logic [3:0] op, input logic [7:0] wd, input logic [7:0] off);
    op_i = op; wdata_i = wd; off_i = off;
    @(negedge clk);
    op_i = 4'd0;
  endtask

  task automatic chk_state(input string req, input int etos, input int edsp,
                           input int ersp, input int ecoll, input int eudf);
    chk(req, "tos", tos_o, etos);
    chk(req, "dsp", dsp_o, edsp);
    chk(req, "rsp", rsp_o, ersp);
    chk(req, "coll", coll_err_o, ecoll);
    chk(req, "udf", udf_err_o, eudf);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    logic [54:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk_state("R1", 8'h00, 24, 0, 0, 0);
    chk("R1", "rd_valid", rd_valid_o, 0);

    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      step(v[54:51], v[50:43], v[42:35]);
      chk_state(tag_of(v[54:51]), v[34:27], v[26:19], v[18:11], v[1], v[0]);
      chk(tag_of(v[54:51]), "rd_valid", rd_valid_o, v[10]);
      if (v[10]) chk(tag_of(v[54:51]), "rd_data", rd_data_o, v[9:2]);
    end

    // R9: low four bits of the base are ignored
    bp_i = 10'h12F;
    step(4'h7, 8'h00, 8'd40);
    chk("R9", "aligned read", rd_data_o, 8'h77);
    // R9: window address wraps modulo memory size (0x3F0 + 0x20 -> 0x010)
    bp_i = 10'h3F0;
    step(4'h8, 8'h5A, 8'h20);
    bp_i = 10'h000;
    step(4'h7, 8'h00, 8'h10);
    chk("R9", "wrap read", rd_data_o, 8'h5A);
    chk("R9", "wrap valid", rd_valid_o, 1);

    // R11: unused codes leave everything as is
    bp_i = 10'h120;
    for (int c = 10; c < 16; c++) begin
      step(4'(c), 8'h3C, 8'd30);
      chk_state("R11", 8'hEE, 25, 0, 0, 0);
      chk("R11", "rd_valid", rd_valid_o, 0);
    end
    step(4'h7, 8'h00, 8'd30);
    chk("R11", "no memory write", rd_data_o == 8'h3C, 0);

    // R1: reset in mid run
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk_state("R1", 8'h00, 24, 0, 0, 0);
    chk("R1", "rd_valid", rd_valid_o, 0);

    // R7: stacks meet
    step(4'h4, 8'h11, 8'h00);
    step(4'h4, 8'h22, 8'h00);
    step(4'h4, 8'h33, 8'h00);
    chk("R5", "rsp after three pushes", rsp_o, 253);
    for (int k = 0; k < 228; k++) step(4'h1, 8'(k), 8'h00);
    chk_state("R7", 8'hE3, 252, 253, 0, 0);
    step(4'h1, 8'h99, 8'h00);
    chk_state("R7", 8'hE3, 252, 253, 1, 0);
    step(4'h4, 8'h98, 8'h00);
    chk_state("R7", 8'hE3, 252, 253, 1, 0);
    step(4'h5, 8'h00, 8'h00);
    chk("R5", "return lifo", rd_data_o, 8'h33);
    chk_state("R7", 8'hE3, 252, 254, 1, 0);
    step(4'h1, 8'h44, 8'h00);
    chk_state("R7", 8'h44, 253, 254, 1, 0);
    step(4'h3, 8'h00, 8'h00);
    chk("R4", "next below top", rd_data_o, 8'hE3);
    step(4'h6, 8'h00, 8'h00);
    chk("R6", "return peek", rd_data_o, 8'h22);
    chk("R6", "rsp held", rsp_o, 254);
    step(4'h9, 8'h00, 8'h00);
    chk("R10", "coll cleared", coll_err_o, 0);

    finish_up();
  end
endmodule